// File: doc/BRIEF.md
# Overlapping Tile Fetcher

This block reads a grayscale frame from a synchronous frame memory and hands it, one tile at a time, to a downstream edge-detection engine. The frame is divided into square core tiles of `CORE` by `CORE` pixels. Each core tile is widened on all four sides by a margin. That margin gives gradient filtering and non-maximum suppression the neighbour pixels they need at the tile borders. The margin is `(MASK+1)/2` pixels for a `MASK` by `MASK` gradient mask, so an extended tile is `CORE+MASK+1` pixels on a side. For example, 64-pixel cores with a 3-tap mask give 68-pixel tiles. Where a margin pixel falls outside the frame, the nearest pixel on the frame border is repeated.

A pulse on `start` fetches one whole frame. Every emitted pixel carries its tile indices, its row and column inside the extended tile, start-of-tile and end-of-tile markers, and a core flag. The core flag tells the consumer which pixels may be written to the final edge map. The output is a valid/ready stream, and a stall on it is passed back to the memory read port through a small credit-counted queue.

Top module: `tile_fetch`

## Requirements
- R1: While reset is held and afterwards until a start is accepted, `out_valid`, `busy` and `rd_en` are all 0.
- R2: A `start` pulse while idle raises `busy` on the next clock edge. `busy` stays 1 until the last pixel of the last tile is accepted, and it is 0 in the cycle after that acceptance.
- R3: Tiles are emitted in raster order with `out_tile_x` varying fastest, for `IMG_W/CORE` by `IMG_H/CORE` tiles. Inside each tile, the `CORE+MASK+1` by `CORE+MASK+1` pixels are emitted in raster order with `out_col` varying fastest, and `out_row`/`out_col` count from 0.
- R4: The pixel word is the memory word at address `y*IMG_W + x`, passed through unchanged (a 16-bit Q8.7 gray value). Here `x = tile_x*CORE + col - (MASK+1)/2` and `y = tile_y*CORE + row - (MASK+1)/2`, each clamped to the frame (x to 0..IMG_W-1, y to 0..IMG_H-1).
- R5: `out_core` is 1 exactly when both `out_row` and `out_col` lie in `(MASK+1)/2 .. (MASK+1)/2+CORE-1`.
- R6: `out_sot` is 1 only on the pixel with row 0 and column 0 of each tile. `out_eot` is 1 only on the pixel with row and column both equal to `CORE+MASK`.
- R7: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value into the next cycle.
- R8: The memory returns `rd_data` one cycle after `rd_en`. Every address issued with `rd_en` is below `IMG_W*IMG_H`.
- R9: A `start` pulse while `busy` is 1 has no effect: the stream in progress continues unchanged and ends after exactly one frame.
- R10: With `out_ready` held at 1, once the first pixel of a frame is valid, a new pixel is valid in every cycle until the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to fetch one frame |
| busy | output | 1 | A frame is in progress |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory word address, row-major |
| rd_data | input | PIX_W | Memory word, one cycle after rd_en |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts the pixel |
| out_pix | output | PIX_W | Pixel word |
| out_tile_x | output | TX_W | Tile column index |
| out_tile_y | output | TY_W | Tile row index |
| out_row | output | RC_W | Row inside the extended tile |
| out_col | output | RC_W | Column inside the extended tile |
| out_core | output | 1 | Pixel lies in the core region |
| out_sot | output | 1 | First pixel of the tile |
| out_eot | output | 1 | Last pixel of the tile |

## Verification
The hardest case to reach is a stall that lands while the queue is full and a memory read is still in flight, since any credit miscount would drop or duplicate a pixel at that moment. The stimulus reaches it by toggling `out_ready` at random with several densities over whole frames, including a frame with heavy stalls. One directed frame uses address-valued memory contents, so that a clamping mistake in a corner tile shows up as a wrong pixel value. Another frame pulses `start` mid-stream to check that the restart is ignored.

// File: rtl/tile_fetch_pkg.sv
package tile_fetch_pkg;

  // Bit width needed to index n items; never below 1.
  function automatic int idx_w(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // Clamp v into 0..hi.
  function automatic int clamp_i(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/tile_scan.sv
module tile_scan
  import tile_fetch_pkg::*;
#(
  parameter int IMG_W  = 32,
  parameter int IMG_H  = 24,
  parameter int CORE   = 8,
  parameter int MARGIN = 2,
  parameter int TX_W   = 2,
  parameter int TY_W   = 2,
  parameter int RC_W   = 4,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              step,
  output logic              active,
  output logic [ADDR_W-1:0] addr,
  output logic [TX_W-1:0]   tile_x,
  output logic [TY_W-1:0]   tile_y,
  output logic [RC_W-1:0]   row,
  output logic [RC_W-1:0]   col,
  output logic              in_core,
  output logic              first_px,
  output logic              last_px
);
  localparam int SIDE    = CORE + 2 * MARGIN;
  localparam int TILES_X = IMG_W / CORE;
  localparam int TILES_Y = IMG_H / CORE;

  logic [TX_W-1:0] tx_q;
  logic [TY_W-1:0] ty_q;
  logic [RC_W-1:0] r_q, c_q;
  logic            act_q;

  logic end_c, end_r, end_tx, end_ty;
  assign end_c  = (c_q == RC_W'(SIDE - 1));
  assign end_r  = (r_q == RC_W'(SIDE - 1));
  assign end_tx = (tx_q == TX_W'(TILES_X - 1));
  assign end_ty = (ty_q == TY_W'(TILES_Y - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      tx_q  <= '0;
      ty_q  <= '0;
      r_q   <= '0;
      c_q   <= '0;
    end else if (launch && !act_q) begin
      act_q <= 1'b1;
      tx_q  <= '0;
      ty_q  <= '0;
      r_q   <= '0;
      c_q   <= '0;
    end else if (act_q && step) begin
      if (!end_c) begin
        c_q <= c_q + 1'b1;
      end else begin
        c_q <= '0;
        if (!end_r) begin
          r_q <= r_q + 1'b1;
        end else begin
          r_q <= '0;
          if (!end_tx) begin
            tx_q <= tx_q + 1'b1;
          end else begin
            tx_q <= '0;
            if (!end_ty) begin
              ty_q <= ty_q + 1'b1;
            end else begin
              ty_q  <= '0;
              act_q <= 1'b0;
            end
          end
        end
      end
    end
  end

  // Frame coordinate of the current sample, with edge replication.
  always_comb begin
    int ix;
    int iy;
    ix = int'(tx_q) * CORE + int'(c_q) - MARGIN;
    iy = int'(ty_q) * CORE + int'(r_q) - MARGIN;
    ix = clamp_i(ix, IMG_W - 1);
    iy = clamp_i(iy, IMG_H - 1);
    addr = ADDR_W'(iy * IMG_W + ix);
  end

  logic row_in, col_in;
  assign row_in = (r_q >= RC_W'(MARGIN)) && (r_q < RC_W'(MARGIN + CORE));
  assign col_in = (c_q >= RC_W'(MARGIN)) && (c_q < RC_W'(MARGIN + CORE));

  assign active   = act_q;
  assign tile_x   = tx_q;
  assign tile_y   = ty_q;
  assign row      = r_q;
  assign col      = c_q;
  assign in_core  = row_in && col_in;
  assign first_px = (r_q == '0) && (c_q == '0);
  assign last_px  = end_r && end_c;

endmodule

// File: rtl/tile_queue.sv
module tile_queue
  import tile_fetch_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2,
  localparam int PTR_W = idx_w(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slot_q[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= nxt(wp_q);
      if (pop)  rp_q <= nxt(rp_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = slot_q[rp_q];
  assign count = cnt_q;

endmodule

// File: rtl/tile_fetch.sv
module tile_fetch
  import tile_fetch_pkg::*;
#(
  parameter int IMG_W      = 32,
  parameter int IMG_H      = 24,
  parameter int CORE       = 8,
  parameter int MASK       = 3,
  parameter int PIX_W      = 16,
  parameter int FIFO_DEPTH = 2,
  localparam int MARGIN  = (MASK + 1) / 2,
  localparam int SIDE    = CORE + MASK + 1,
  localparam int TILES_X = IMG_W / CORE,
  localparam int TILES_Y = IMG_H / CORE,
  localparam int TX_W    = idx_w(TILES_X),
  localparam int TY_W    = idx_w(TILES_Y),
  localparam int RC_W    = idx_w(SIDE),
  localparam int ADDR_W  = idx_w(IMG_W * IMG_H)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [PIX_W-1:0]  rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_pix,
  output logic [TX_W-1:0]   out_tile_x,
  output logic [TY_W-1:0]   out_tile_y,
  output logic [RC_W-1:0]   out_row,
  output logic [RC_W-1:0]   out_col,
  output logic              out_core,
  output logic              out_sot,
  output logic              out_eot
);
  localparam int TAG_W = TY_W + TX_W + 2 * RC_W + 3;
  localparam int ENT_W = PIX_W + TAG_W;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic              gen_active;
  logic [ADDR_W-1:0] gen_addr;
  logic [TX_W-1:0]   gen_tx;
  logic [TY_W-1:0]   gen_ty;
  logic [RC_W-1:0]   gen_row, gen_col;
  logic              gen_core, gen_first, gen_last;
  logic              issue;
  logic              busy_q;

  tile_scan #(
    .IMG_W (IMG_W), .IMG_H (IMG_H), .CORE (CORE), .MARGIN (MARGIN),
    .TX_W (TX_W), .TY_W (TY_W), .RC_W (RC_W), .ADDR_W (ADDR_W)
  ) scan_i (
    .clk      (clk),
    .rst      (rst),
    .launch   (start && !busy_q),
    .step     (issue),
    .active   (gen_active),
    .addr     (gen_addr),
    .tile_x   (gen_tx),
    .tile_y   (gen_ty),
    .row      (gen_row),
    .col      (gen_col),
    .in_core  (gen_core),
    .first_px (gen_first),
    .last_px  (gen_last)
  );

  // One read in flight: its tag travels beside the memory latency.
  logic             inflight_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) inflight_q <= 1'b0;
    else     inflight_q <= issue;
  end

  always_ff @(posedge clk) begin
    if (issue) tag_q <= {gen_ty, gen_tx, gen_row, gen_col, gen_core, gen_first, gen_last};
  end

  logic [CNT_W-1:0] q_count;
  logic [ENT_W-1:0] q_head;
  logic             pop;

  tile_queue #(.DATA_W (ENT_W), .DEPTH (FIFO_DEPTH)) queue_i (
    .clk   (clk),
    .rst   (rst),
    .push  (inflight_q),
    .din   ({rd_data, tag_q}),
    .pop   (pop),
    .dout  (q_head),
    .count (q_count)
  );

  assign out_valid = (q_count != '0);
  assign pop       = out_valid && out_ready;

  // Credit: entries held plus the read in flight, minus this cycle's pop.
  always_comb begin
    int occ;
    occ   = int'(q_count) + int'(inflight_q) - int'(pop);
    issue = gen_active && (occ < FIFO_DEPTH);
  end

  assign rd_en   = issue;
  assign rd_addr = gen_addr;

  assign {out_pix, out_tile_y, out_tile_x, out_row, out_col,
          out_core, out_sot, out_eot} = q_head;

  logic final_beat;
  assign final_beat = pop && out_eot &&
                      (out_tile_x == TX_W'(TILES_X - 1)) &&
                      (out_tile_y == TY_W'(TILES_Y - 1));

  always_ff @(posedge clk) begin
    if (rst)                  busy_q <= 1'b0;
    else if (!busy_q && start) busy_q <= 1'b1;
    else if (final_beat)      busy_q <= 1'b0;
  end

  assign busy = busy_q;

endmodule

// File: rtl/tile_fetch_chk.sv
module tile_fetch_chk
  import tile_fetch_pkg::*;
#(
  parameter int IMG_W = 32,
  parameter int IMG_H = 24,
  parameter int CORE  = 8,
  parameter int MASK  = 3,
  parameter int PIX_W = 16,
  localparam int MARGIN  = (MASK + 1) / 2,
  localparam int SIDE    = CORE + MASK + 1,
  localparam int TILES_X = IMG_W / CORE,
  localparam int TILES_Y = IMG_H / CORE,
  localparam int TX_W    = idx_w(TILES_X),
  localparam int TY_W    = idx_w(TILES_Y),
  localparam int RC_W    = idx_w(SIDE),
  localparam int ADDR_W  = idx_w(IMG_W * IMG_H)
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PIX_W-1:0]  out_pix,
  input logic [TX_W-1:0]   out_tile_x,
  input logic [TY_W-1:0]   out_tile_y,
  input logic [RC_W-1:0]   out_row,
  input logic [RC_W-1:0]   out_col,
  input logic              out_core,
  input logic              out_sot,
  input logic              out_eot
);
  // R7
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) &&
      $stable(out_row) && $stable(out_col) && $stable(out_tile_x) &&
      $stable(out_tile_y) && $stable(out_core) && $stable(out_sot) && $stable(out_eot)));

  // R8
  a_r8_addr_range: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (int'(rd_addr) < IMG_W * IMG_H));

  // R6
  a_r6_sot_origin: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sot) |-> (out_row == '0 && out_col == '0));

  // R6
  a_r6_eot_corner: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eot) |-> (int'(out_row) == SIDE - 1 && int'(out_col) == SIDE - 1));

  // R1, R2
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!out_valid && !rd_en));

  // R5
  a_r5_margin_not_core: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (int'(out_row) < MARGIN || int'(out_col) < MARGIN)) |-> !out_core);

  // R3
  a_r3_tile_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_tile_x) < TILES_X && int'(out_tile_y) < TILES_Y));

endmodule

bind tile_fetch tile_fetch_chk #(
  .IMG_W (IMG_W), .IMG_H (IMG_H), .CORE (CORE), .MASK (MASK), .PIX_W (PIX_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_pix    (out_pix),
  .out_tile_x (out_tile_x),
  .out_tile_y (out_tile_y),
  .out_row    (out_row),
  .out_col    (out_col),
  .out_core   (out_core),
  .out_sot    (out_sot),
  .out_eot    (out_eot)
);

// File: tb/tile_fetch_tb_top.sv
module tile_fetch_tb_top;
  import tile_fetch_pkg::*;

  localparam int IMG_W   = 32;
  localparam int IMG_H   = 24;
  localparam int CORE    = 8;
  localparam int MASK    = 3;
  localparam int PIX_W   = 16;
  localparam int MARGIN  = (MASK + 1) / 2;
  localparam int SIDE    = CORE + MASK + 1;
  localparam int TILES_X = IMG_W / CORE;
  localparam int TILES_Y = IMG_H / CORE;
  localparam int TX_W    = idx_w(TILES_X);
  localparam int TY_W    = idx_w(TILES_Y);
  localparam int RC_W    = idx_w(SIDE);
  localparam int ADDR_W  = idx_w(IMG_W * IMG_H);
  localparam int TOTAL   = TILES_X * TILES_Y * SIDE * SIDE;
  localparam int WDOG    = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              busy;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [PIX_W-1:0]  rd_data;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [PIX_W-1:0]  out_pix;
  logic [TX_W-1:0]   out_tile_x;
  logic [TY_W-1:0]   out_tile_y;
  logic [RC_W-1:0]   out_row, out_col;
  logic              out_core, out_sot, out_eot;

  tile_fetch #(
    .IMG_W (IMG_W), .IMG_H (IMG_H), .CORE (CORE), .MASK (MASK), .PIX_W (PIX_W)
  ) dut_i (
    .clk (clk), .rst (rst), .start (start), .busy (busy),
    .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
    .out_valid (out_valid), .out_ready (out_ready), .out_pix (out_pix),
    .out_tile_x (out_tile_x), .out_tile_y (out_tile_y),
    .out_row (out_row), .out_col (out_col), .out_core (out_core),
    .out_sot (out_sot), .out_eot (out_eot)
  );

  always #4 clk = ~clk;

  // Frame memory model: one-cycle synchronous read (R8).
  logic [PIX_W-1:0] mem [IMG_W * IMG_H];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc = 0;
  bit  timeout = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG && !timeout) timeout <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_pix(input int tx, input int ty, input int r, input int c);
    int x, y;
    x = clamp_i(tx * CORE + c - MARGIN, IMG_W - 1);
    y = clamp_i(ty * CORE + r - MARGIN, IMG_H - 1);
    return int'(mem[y * IMG_W + x]);
  endfunction

  function automatic bit exp_core(input int r, input int c);
    return (r >= MARGIN) && (r < MARGIN + CORE) && (c >= MARGIN) && (c < MARGIN + CORE);
  endfunction

  task automatic fill_random();
    for (int i = 0; i < IMG_W * IMG_H; i++) mem[i] = PIX_W'($urandom) & 16'h7FFF;
  endtask

  task automatic fill_index();
    for (int i = 0; i < IMG_W * IMG_H; i++) mem[i] = PIX_W'(i);
  endtask

  // mode 0: ready always high; 1: light stalls; 2: light stalls + restart pulse; 3: heavy stalls
  task automatic run_frame(input int mode);
    int tx = 0, ty = 0, r = 0, c = 0;
    int beats = 0, bubbles = 0;
    bit prev_stall = 1'b0;
    logic [PIX_W-1:0] s_pix = '0;
    int s_row = 0, s_col = 0, s_tx = 0, s_ty = 0;
    logic [2:0] s_flags = '0;
    @(negedge clk);
    start = 1'b1;
    while (beats < TOTAL && !timeout) begin
      @(negedge clk);
      start = (mode == 2 && beats == 300) ? 1'b1 : 1'b0;
      case (mode)
        0:       out_ready = 1'b1;
        3:       out_ready = ($urandom % 3 == 0);
        default: out_ready = ($urandom % 4 != 0);
      endcase
      if (rd_en) chk(int'(rd_addr) < IMG_W * IMG_H, "R8", "read address", int'(rd_addr), IMG_W * IMG_H - 1);
      if (prev_stall) begin
        chk(out_valid && out_pix == s_pix && int'(out_row) == s_row && int'(out_col) == s_col &&
            int'(out_tile_x) == s_tx && int'(out_tile_y) == s_ty &&
            {out_core, out_sot, out_eot} == s_flags,
            "R7", "hold under stall", int'(out_pix), int'(s_pix));
      end
      if (beats > 0 && !out_valid) bubbles++;
      if (out_valid && out_ready) begin
        if (beats == 0) chk(busy == 1'b1, "R2", "busy during frame", int'(busy), 1);
        chk(int'(out_tile_x) == tx && int'(out_tile_y) == ty, "R3", "tile index",
            int'(out_tile_y) * 256 + int'(out_tile_x), ty * 256 + tx);
        chk(int'(out_row) == r && int'(out_col) == c, "R3", "row/col",
            int'(out_row) * 256 + int'(out_col), r * 256 + c);
        chk(int'(out_pix) == exp_pix(tx, ty, r, c), (mode == 2) ? "R9" : "R4", "pixel",
            int'(out_pix), exp_pix(tx, ty, r, c));
        chk(out_core == exp_core(r, c), "R5", "core flag", int'(out_core), int'(exp_core(r, c)));
        chk(out_sot == (r == 0 && c == 0) && out_eot == (r == SIDE - 1 && c == SIDE - 1),
            "R6", "tile markers", int'({out_sot, out_eot}),
            int'({(r == 0 && c == 0), (r == SIDE - 1 && c == SIDE - 1)}));
        beats++;
        if (c < SIDE - 1) c++;
        else begin
          c = 0;
          if (r < SIDE - 1) r++;
          else begin
            r = 0;
            if (tx < TILES_X - 1) tx++;
            else begin tx = 0; ty++; end
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      s_pix = out_pix; s_row = int'(out_row); s_col = int'(out_col);
      s_tx = int'(out_tile_x); s_ty = int'(out_tile_y);
      s_flags = {out_core, out_sot, out_eot};
    end
    start = 1'b0;
    @(negedge clk);
    chk(!busy && !out_valid, (mode == 2) ? "R9" : "R2", "idle after frame",
        int'({busy, out_valid}), 0);
    if (mode == 0) chk(bubbles == 0, "R10", "bubbles with ready high", bubbles, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fill_index();
    repeat (3) @(negedge clk);
    chk(!out_valid && !busy && !rd_en, "R1", "outputs in reset", int'({out_valid, busy, rd_en}), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(!out_valid && !busy && !rd_en, "R1", "idle after reset", int'({out_valid, busy, rd_en}), 0);

    run_frame(0);          // directed: index pattern exposes clamping (R4, R10)
    fill_random();
    run_frame(1);
    fill_random();
    run_frame(2);          // restart pulse while busy (R9)
    fill_random();
    run_frame(3);

    if (timeout) chk(1'b0, "R2", "watchdog expired", cyc, WDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule